// File: doc/BRIEF.md
# Prioritized Interrupt Level Controller

This block gathers fourteen hardware interrupt sources into a pending-request register and qualifies them against an enable register that includes a global master bit. From the qualified bits it drives a 3-bit priority level toward a processor. The sources sit in fixed groups, and each group shares one of the levels 1 to 6. Level 7 is left free for a non-maskable source that lies outside the block.

Software reaches both registers over a small word-wide bus. Two addresses return the registers' contents, and two addresses take set/clear control words. In a control word, the top bit chooses between setting and clearing. Each data bit that is 1 marks a register bit to change, and each data bit that is 0 leaves that bit as it is. Peripherals raise requests with single-cycle pulses, one input per source. Software acknowledges a request by writing a clear word for its bit. Software can also raise any request, including the software-interrupt source, by writing a set word.

Top module: `irq_level_ctrl`

## Requirements
- R1: After reset, the enable register, the request register and `irq_level` are all zero.
- R2: Address 0 reads the 15-bit enable register and address 1 reads the 14-bit request register, both zero-extended to 16 bits. Addresses 2 and 3 read as 0. A write to address 2 controls the enable register and a write to address 3 controls the request register. Writes to addresses 0 and 1 have no effect.
- R3: A control word with bit 15 = 1 sets every register bit whose data bit is 1.
- R4: A control word with bit 15 = 0 clears every register bit whose data bit is 1. Register bits whose data bit is 0 keep their value, so writing 0x0020 to address 3 clears only request bit 5 (vertical blank).
- R5: A one-cycle pulse on `src_pulse[i]` sets request bit i. When the pulse coincides with a software clear of the same bit, the bit ends up set.
- R6: While enable bit 14 (master) is 0, `irq_level` is 0 regardless of the individual enables.
- R7: The source-to-level map is: bits 0–2 give level 1, bit 3 gives level 2, bits 4–6 give level 3, bits 7–10 give level 4, bits 11–12 give level 5, and bit 13 gives level 6.
- R8: `irq_level` is the highest level among the bits that are pending, individually enabled and master-enabled. It is 0 when no bit qualifies.
- R9: `irq_level` is registered. It reflects the register contents one clock after they change.
- R10: `irq_level` never takes the value 7.
- R11: Software can raise any request bit through address 3, including bit 2 (software interrupt), and that bit then drives its level like a hardware request does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_addr | input | 2 | Register address for read and write |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 16 | Control word (bit 15 = set/clear select) |
| bus_rdata | output | 16 | Read data for the current address |
| src_pulse | input | 14 | Hardware request pulses, one per source |
| irq_level | output | 3 | Registered priority level toward the processor |

## Verification
The bench builds the block with its default parameters: 14 sources, a 16-bit bus word and a registered level output. With these defaults the full group-to-level map and the master bit at position 14 are in reach. A table of enable/request pairs covers each level on its own, mixes of groups where the highest one must win, and masking by the individual enables and by the master bit. Directed cases then check reset, the single-bit acknowledge, the race between a pulse and a clear, the one-clock latency and the reads at the write addresses.

// File: rtl/irq_pkg.sv
package irq_pkg;

   localparam int unsigned LVL_W = 3;

   localparam logic [1:0] A_EN_STAT  = 2'd0;
   localparam logic [1:0] A_REQ_STAT = 2'd1;
   localparam logic [1:0] A_EN_CTRL  = 2'd2;
   localparam logic [1:0] A_REQ_CTRL = 2'd3;

   // Fixed group map from source index to shared level (R7)
   function automatic logic [LVL_W-1:0] src_level(input int unsigned idx);
      if (idx <= 2)       return 3'd1;
      else if (idx == 3)  return 3'd2;
      else if (idx <= 6)  return 3'd3;
      else if (idx <= 10) return 3'd4;
      else if (idx <= 12) return 3'd5;
      else                return 3'd6;
   endfunction

endpackage

// File: rtl/irq_setclr_reg.sv
module irq_setclr_reg #(
   parameter int unsigned W      = 14,
   parameter bit          HW_SET = 1'b1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         wr_en,
   input  logic         wr_op,
   input  logic [W-1:0] wr_mask,
   input  logic [W-1:0] hw_set,
   output logic [W-1:0] q
);

   if (W < 1) begin : g_bad_w
      $error("irq_setclr_reg: W must be at least 1");
   end

   logic [W-1:0] hw_eff;
   logic [W-1:0] sw_next;
   logic [W-1:0] q_next;

   if (HW_SET) begin : g_hw
      assign hw_eff = hw_set;
   end else begin : g_no_hw
      logic unused_hw;
      assign unused_hw = ^hw_set;
      assign hw_eff    = '0;
   end

   always_comb begin
      sw_next = q;
      if (wr_en) begin
         if (wr_op) sw_next = q | wr_mask;
         else       sw_next = q & ~wr_mask;
      end
      q_next = sw_next | hw_eff;   // hardware set wins (R5)
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q <= '0;
      else        q <= q_next;
   end

   p_set_op_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_op) |=> ((q & $past(wr_mask)) == $past(wr_mask)));

   p_clear_op_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !wr_op) |=> ((q & $past(wr_mask) & ~$past(hw_eff)) == '0));

   p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (!wr_en && (hw_eff == '0)) |=> $stable(q));

   p_hw_wins_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (hw_eff != '0) |=> ((q & $past(hw_eff)) == $past(hw_eff)));

endmodule

// File: rtl/irq_prio_enc.sv
module irq_prio_enc
   import irq_pkg::*;
#(
   parameter int unsigned NUM_SRC = 14,
   parameter bit          REG_OUT = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_SRC-1:0] req,
   input  logic [NUM_SRC:0]   en,
   output logic [LVL_W-1:0]   lvl_o
);

   localparam int unsigned MASTER = NUM_SRC;

   logic [NUM_SRC-1:0] pending;
   logic [LVL_W-1:0]   lvl_c;

   assign pending = req & en[NUM_SRC-1:0] & {NUM_SRC{en[MASTER]}};

   always_comb begin
      lvl_c = '0;
      for (int unsigned i = 0; i < NUM_SRC; i++) begin
         if (pending[i] && (src_level(i) > lvl_c)) lvl_c = src_level(i);
      end
   end

   if (REG_OUT) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) lvl_o <= '0;
         else        lvl_o <= lvl_c;
      end

      p_master_off_r6: assert property (@(posedge clk) disable iff (!rst_n)
         !en[MASTER] |=> (lvl_o == '0));

      p_idle_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
         (pending == '0) |=> (lvl_o == '0));

      p_busy_nonzero_r8: assert property (@(posedge clk) disable iff (!rst_n)
         (pending != '0) |=> (lvl_o != '0));
   end else begin : g_comb
      logic unused_clk;
      assign unused_clk = clk;
      assign lvl_o      = lvl_c;
   end

   p_never_nmi_r10: assert property (@(posedge clk) disable iff (!rst_n)
      lvl_o != 3'd7);

endmodule

// File: rtl/irq_level_ctrl.sv
module irq_level_ctrl
   import irq_pkg::*;
#(
   parameter int unsigned NUM_SRC = 14,
   parameter int unsigned DATA_W  = 16,
   parameter bit          REG_OUT = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [1:0]         bus_addr,
   input  logic               bus_we,
   input  logic [DATA_W-1:0]  bus_wdata,
   output logic [DATA_W-1:0]  bus_rdata,
   input  logic [NUM_SRC-1:0] src_pulse,
   output logic [LVL_W-1:0]   irq_level
);

   localparam int unsigned EN_W   = NUM_SRC + 1;
   localparam int unsigned OP_BIT = DATA_W - 1;

   if (NUM_SRC != 14) begin : g_bad_src
      $error("irq_level_ctrl: the level map is defined for 14 sources");
   end
   if (DATA_W != EN_W + 1) begin : g_bad_dw
      $error("irq_level_ctrl: DATA_W must be NUM_SRC + 2");
   end

   logic [EN_W-1:0]    en_q;
   logic [NUM_SRC-1:0] req_q;
   logic               en_we;
   logic               req_we;

   assign en_we  = bus_we && (bus_addr == A_EN_CTRL);
   assign req_we = bus_we && (bus_addr == A_REQ_CTRL);

   irq_setclr_reg #(.W(EN_W), .HW_SET(1'b0)) u_en_reg (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (en_we),
      .wr_op   (bus_wdata[OP_BIT]),
      .wr_mask (bus_wdata[EN_W-1:0]),
      .hw_set  ({EN_W{1'b0}}),
      .q       (en_q)
   );

   irq_setclr_reg #(.W(NUM_SRC), .HW_SET(1'b1)) u_req_reg (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (req_we),
      .wr_op   (bus_wdata[OP_BIT]),
      .wr_mask (bus_wdata[NUM_SRC-1:0]),
      .hw_set  (src_pulse),
      .q       (req_q)
   );

   irq_prio_enc #(.NUM_SRC(NUM_SRC), .REG_OUT(REG_OUT)) u_enc (
      .clk   (clk),
      .rst_n (rst_n),
      .req   (req_q),
      .en    (en_q),
      .lvl_o (irq_level)
   );

   always_comb begin
      case (bus_addr)
         A_EN_STAT:  bus_rdata = DATA_W'(en_q);
         A_REQ_STAT: bus_rdata = DATA_W'(req_q);
         default:    bus_rdata = '0;
      endcase
   end

   p_stat_write_ignored_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_we && !bus_addr[1] && (src_pulse == '0)) |=> ($stable(en_q) && $stable(req_q)));

endmodule

// File: tb/test_irq_level_ctrl.sv
module test_irq_level_ctrl;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [1:0]  bus_addr = '0;
   logic        bus_we = 1'b0;
   logic [15:0] bus_wdata = '0;
   logic [15:0] bus_rdata;
   logic [13:0] src_pulse = '0;
   logic [2:0]  irq_level;

   int checks = 0;
   int errors = 0;

   always #2.5 clk = ~clk;   // 200 MHz

   irq_level_ctrl i_irq_level_ctrl (
      .clk       (clk),
      .rst_n     (rst_n),
      .bus_addr  (bus_addr),
      .bus_we    (bus_we),
      .bus_wdata (bus_wdata),
      .bus_rdata (bus_rdata),
      .src_pulse (src_pulse),
      .irq_level (irq_level)
   );

   // {enable set word, request set word, expected level}
   localparam logic [47:0] VEC [12] = '{
      {16'h4001, 16'h0001, 16'd1},   // R7 group 1
      {16'h4008, 16'h0008, 16'd2},   // R7 group 2
      {16'h4070, 16'h0040, 16'd3},   // R7 group 3
      {16'h4780, 16'h0400, 16'd4},   // R7 group 4
      {16'h5800, 16'h1000, 16'd5},   // R7 group 5
      {16'h6000, 16'h2000, 16'd6},   // R7 group 6
      {16'h3FFF, 16'h3FFF, 16'd0},   // R6 master off
      {16'h7FFF, 16'h3FFF, 16'd6},   // R8 highest wins
      {16'h401F, 16'h3FFF, 16'd3},   // R8 masked upper groups
      {16'h4000, 16'h3FFF, 16'd0},   // R8 nothing enabled
      {16'h47FF, 16'h0804, 16'd1},   // R8 bit 11 masked, soft bit 2
      {16'h5FFF, 16'h1803, 16'd5}    // R8 mixed
   };

   task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic wr(input logic [1:0] a, input logic [15:0] d);
      @(negedge clk);
      bus_addr  = a;
      bus_wdata = d;
      bus_we    = 1'b1;
      @(negedge clk);
      bus_we    = 1'b0;
   endtask

   task automatic rd(input logic [1:0] a, output logic [15:0] d);
      bus_addr = a;
      #1;
      d = bus_rdata;
   endtask

   task automatic clear_all();
      wr(2'd2, 16'h7FFF);
      wr(2'd3, 16'h3FFF);
   endtask

   initial begin
      #1_000_000;
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      logic [15:0] d;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      rd(2'd0, d); chk("R1 enable", d, 16'h0000);
      rd(2'd1, d); chk("R1 request", d, 16'h0000);
      chk("R1 level", {13'd0, irq_level}, 16'd0);

      // Table walk: R7, R8, R6, R11
      for (int k = 0; k < 12; k++) begin
         clear_all();
         wr(2'd2, 16'h8000 | VEC[k][47:32]);
         wr(2'd3, 16'h8000 | VEC[k][31:16]);
         @(negedge clk);
         chk($sformatf("R8 vector %0d level", k), {13'd0, irq_level}, VEC[k][15:0]);
         rd(2'd0, d); chk($sformatf("R3 vector %0d enable", k), d, VEC[k][47:32] & 16'h7FFF);
         rd(2'd1, d); chk($sformatf("R11 vector %0d request", k), d, VEC[k][31:16] & 16'h3FFF);
      end

      // R4: 0x0020 clears only vertical blank
      clear_all();
      wr(2'd3, 16'hBFFF);
      wr(2'd3, 16'h0020);
      rd(2'd1, d); chk("R4 single clear", d, 16'h3FDF);

      // R4: clear on enable leaves zero data bits alone
      wr(2'd2, 16'hC0F0);
      wr(2'd2, 16'h0030);
      rd(2'd0, d); chk("R4 enable clear", d, 16'h40C0);

      // R2: write at status address ignored, write addresses read as zero
      wr(2'd0, 16'hFFFF);
      wr(2'd1, 16'h3FFF);
      rd(2'd0, d); chk("R2 enable unchanged", d, 16'h40C0);
      rd(2'd1, d); chk("R2 request unchanged", d, 16'h3FDF);
      rd(2'd2, d); chk("R2 addr2 reads zero", d, 16'h0000);
      rd(2'd3, d); chk("R2 addr3 reads zero", d, 16'h0000);

      // R5: hardware pulse sets its bit
      clear_all();
      @(negedge clk); src_pulse = 14'h0100;
      @(negedge clk); src_pulse = '0;
      rd(2'd1, d); chk("R5 pulse sets", d, 16'h0100);

      // R5: pulse and clear of the same bit in one cycle -> set
      @(negedge clk);
      bus_addr = 2'd3; bus_wdata = 16'h0120; bus_we = 1'b1; src_pulse = 14'h0020;
      @(negedge clk);
      bus_we = 1'b0; src_pulse = '0;
      rd(2'd1, d); chk("R5 set wins", d, 16'h0020);

      // R9: level lags the register by one clock; R11 soft bit
      clear_all();
      wr(2'd2, 16'hC004);
      wr(2'd3, 16'h8004);
      chk("R9 level before", {13'd0, irq_level}, 16'd0);
      @(negedge clk);
      chk("R9 level after", {13'd0, irq_level}, 16'd1);

      // R6: clearing master drops level
      wr(2'd2, 16'h4000);
      @(negedge clk);
      chk("R6 master cleared", {13'd0, irq_level}, 16'd0);

      // R10: everything on, never 7
      wr(2'd2, 16'hFFFF);
      wr(2'd3, 16'hFFFF);
      @(negedge clk);
      chk("R10 level not 7", {13'd0, irq_level}, 16'd6);

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule